// File: doc/BRIEF.md
# SPI Master User-Transfer Engine

This block is a memory-mapped SPI master. Software stages up to 64 bytes in a register-mapped data buffer, sets how many bits to shift, and chooses whether the output data phase and input sampling are on. It then writes a start command. The engine asserts chip select and runs the bit count in SPI mode 0, most significant bit first. When input sampling is on, each received bit overwrites the buffer bit it came from. When the last bit is done, the engine sets a sticky completion flag.

Chip select can stay active after a transfer ends, so software can chain several transfers into one frame on the wire. A soft-reset command stops an ongoing transfer and returns the engine to idle. The mode bit in the status register always reads as master.

The register bus is a simple 32-bit port with byte addresses. Writes take effect at the next clock edge. Read data is combinational from the address. SCLK runs at the system clock divided by 2·HALF_CYC.

Top module: `spi_user_xfer`

## Requirements
- R1: After reset, csNOut is 1, sclkOut is 0, and both the command word (0x00) and the status word (0x30) read as zero.
- R2: Writing a word with bit 18 set to address 0x00 while idle starts a transfer. csNOut goes low, and bit 18 of 0x00 reads 1 while the transfer runs.
- R3: A transfer produces exactly N+1 SCLK rising edges, where N is the value in bits [25:17] of address 0x20 (0 to 511).
- R4: Transfer bit i comes from buffer byte i/8, bit 7−(i mod 8). Byte b sits in word b/4 (at 0x40+4·(b/4)), bits [8(b mod 4)+7 : 8(b mod 4)]. MOSI changes only while SCLK is low, SCLK idles low, and one SCLK period is 2·HALF_CYC clocks.
- R5: Bit 27 of 0x1C enables the data-out phase. When it is 0, MOSI stays 0 for the whole transfer.
- R6: When bit 0 of 0x1C is 1, the MISO value sampled on each rising edge is written into the buffer at the position of that transfer bit. When it is 0, the buffer is left unchanged.
- R7: Bit 4 of 0x30 sets when the last bit completes and then holds. A write to 0x30 with bit 4 at 0 clears it. A write with bit 4 at 1 leaves it set.
- R8: If bit 30 of 0x2C is 1 when a transfer ends, csNOut stays low afterwards. If it is 0, csNOut returns to 1.
- R9: A start write that arrives while a transfer is running is ignored. No extra bits are shifted.
- R10: Writing bit 31 of 0x30 aborts any transfer and clears the done flag. It also stops SCLK and sets csNOut to 1. Bit 30 of 0x30 (mode) always reads 0, meaning master, whatever is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe for one clock |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| sclkOut | output | 1 | SPI serial clock, idle low |
| mosiOut | output | 1 | Serial data to the target |
| misoIn | input | 1 | Serial data from the target |
| csNOut | output | 1 | Active-low chip select |

## Verification
The bench uses a target model that returns a fixed 64-bit response pattern and records every MOSI bit at the rising edges. The tests vary the bit count: one bit, a part byte of 13 bits, whole bytes, and the full 512 bits. These lengths separate counting errors from bit-order and byte-lane errors.

Runs with the output phase off or with input sampling off show that each enable controls only its own direction. Chained runs with chip select held, the done-flag write semantics, a start written mid-transfer and a soft reset mid-transfer each test the control path separately from the shift path.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int BUF_BYTES = 64;
  localparam int BUF_BITS  = BUF_BYTES * 8;
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int IDX_W     = $clog2(BUF_BITS);
  localparam int WORD_W    = $clog2(BUF_WORDS);

  // register byte offsets
  localparam int OFS_CMD    = 'h00;
  localparam int OFS_USER   = 'h1C;
  localparam int OFS_BITCNT = 'h20;
  localparam int OFS_CS     = 'h2C;
  localparam int OFS_STAT   = 'h30;
  localparam int OFS_BUF    = 'h40;

  // field positions
  localparam int B_START  = 18;
  localparam int B_DOUT   = 27;
  localparam int B_DIN    = 0;
  localparam int B_CNTLSB = 17;
  localparam int B_HOLD   = 30;
  localparam int B_DONE   = 4;
  localparam int B_MODE   = 30;
  localparam int B_SRST   = 31;

  typedef struct packed {
    logic             loadMosi;
    logic             sampleMiso;
    logic [IDX_W-1:0] bitIdx;
  } dpStrobe_t;

  // transfer bit index -> flat buffer bit (MSB of each byte first)
  function automatic logic [IDX_W-1:0] bitPos(input logic [IDX_W-1:0] i);
    return {i[IDX_W-1:3], ~i[2:0]};
  endfunction
endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       ctrlRdata,
  output logic              sclk,
  output logic              csN,
  output logic              busy,
  output logic              done,
  output logic              doutEn,
  output dpStrobe_t         strobe
);
  localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [IDX_W-1:0] lastIdx, bitIdx;
  logic [HC_W-1:0]  halfCnt;
  logic             dinEn, holdCs;

  logic cmdWr, userWr, cntWr, csWr, statWr, startReq, softRst, edgeNow;
  assign cmdWr    = busWrEn && (busAddr == ADDR_W'(OFS_CMD));
  assign userWr   = busWrEn && (busAddr == ADDR_W'(OFS_USER));
  assign cntWr    = busWrEn && (busAddr == ADDR_W'(OFS_BITCNT));
  assign csWr     = busWrEn && (busAddr == ADDR_W'(OFS_CS));
  assign statWr   = busWrEn && (busAddr == ADDR_W'(OFS_STAT));
  assign softRst  = statWr && busWdata[B_SRST];
  assign startReq = cmdWr && busWdata[B_START] && !softRst;
  assign edgeNow  = busy && (halfCnt == HC_W'(HALF_CYC - 1)) && !softRst;

  // configuration registers (kept across soft reset)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutEn  <= 1'b0;
      dinEn   <= 1'b0;
      lastIdx <= '0;
      holdCs  <= 1'b0;
    end else begin
      if (userWr) begin
        doutEn <= busWdata[B_DOUT];
        dinEn  <= busWdata[B_DIN];
      end
      if (cntWr) lastIdx <= busWdata[B_CNTLSB +: IDX_W];
      if (csWr)  holdCs  <= busWdata[B_HOLD];
    end
  end

  // transfer sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      csN     <= 1'b1;
      done    <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (softRst) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      csN     <= 1'b1;
      done    <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else begin
      if (statWr) done <= done & busWdata[B_DONE];
      if (!busy) begin
        if (startReq) begin
          busy    <= 1'b1;
          csN     <= 1'b0;
          bitIdx  <= '0;
          halfCnt <= '0;
        end
      end else if (edgeNow) begin
        halfCnt <= '0;
        sclk    <= ~sclk;
        if (sclk) begin
          if (bitIdx == lastIdx) begin
            busy <= 1'b0;
            done <= 1'b1;
            csN  <= ~holdCs;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // strobes towards the datapath
  always_comb begin
    strobe.loadMosi   = (!busy && startReq) ||
                        (edgeNow && sclk && (bitIdx != lastIdx));
    strobe.sampleMiso = edgeNow && !sclk && dinEn;
    strobe.bitIdx     = !busy ? '0 : (sclk ? bitIdx + 1'b1 : bitIdx);
  end

  always_comb begin
    ctrlRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_CMD):    ctrlRdata[B_START] = busy;
      ADDR_W'(OFS_USER): begin
        ctrlRdata[B_DOUT] = doutEn;
        ctrlRdata[B_DIN]  = dinEn;
      end
      ADDR_W'(OFS_BITCNT): ctrlRdata[B_CNTLSB +: IDX_W] = lastIdx;
      ADDR_W'(OFS_CS):     ctrlRdata[B_HOLD] = holdCs;
      ADDR_W'(OFS_STAT):   ctrlRdata[B_DONE] = done;  // mode bit stays 0
      default:             ctrlRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_xfer_dp.sv
module spi_xfer_dp
  import spi_xfer_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWdata,
  input  dpStrobe_t         strobe,
  input  logic              doutEn,
  input  logic              misoIn,
  output logic              mosi,
  output logic [31:0]       bufRdata
);
  logic [BUF_BITS-1:0] bufBits;
  logic [WORD_W-1:0]   wordIdx;
  logic                inBuf;
  logic [IDX_W-1:0]    tgtPos;

  assign wordIdx = busAddr[2 +: WORD_W];
  assign inBuf   = busAddr[ADDR_W-1];
  assign tgtPos  = bitPos(strobe.bitIdx);

  for (genvar w = 0; w < BUF_WORDS; w++) begin : gWord
    logic wordWr, hitSample;
    assign wordWr    = busWrEn && inBuf && (wordIdx == WORD_W'(w));
    assign hitSample = strobe.sampleMiso && (tgtPos[IDX_W-1:5] == WORD_W'(w));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufBits[32*w +: 32] <= '0;
      end else begin
        if (wordWr)    bufBits[32*w +: 32] <= busWdata;
        if (hitSample) bufBits[32*w + int'(tgtPos[4:0])] <= misoIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mosi <= 1'b0;
    else if (strobe.loadMosi) mosi <= doutEn & bufBits[tgtPos];
  end

  assign bufRdata = bufBits[32*wordIdx +: 32];
endmodule

// File: rtl/spi_user_xfer.sv
module spi_user_xfer
  import spi_xfer_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sclkOut,
  output logic              mosiOut,
  input  logic              misoIn,
  output logic              csNOut
);
  dpStrobe_t   strobe;
  logic [31:0] ctrlRdata, bufRdata;
  logic        ctrlBusy, ctrlDone, doutEn;

  spi_xfer_ctrl #(.ADDR_W(ADDR_W), .HALF_CYC(HALF_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .ctrlRdata(ctrlRdata), .sclk(sclkOut),
    .csN(csNOut), .busy(ctrlBusy), .done(ctrlDone), .doutEn(doutEn),
    .strobe(strobe)
  );

  spi_xfer_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .strobe(strobe), .doutEn(doutEn),
    .misoIn(misoIn), .mosi(mosiOut), .bufRdata(bufRdata)
  );

  assign busRdata = busAddr[ADDR_W-1] ? bufRdata : ctrlRdata;
endmodule

// File: rtl/spi_user_xfer_chk.sv
module spi_user_xfer_chk
  import spi_xfer_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclkOut,
  input logic              mosiOut,
  input logic              csNOut,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn
);
  logic statWr;
  assign statWr = busWrEn && (busAddr == ADDR_W'(OFS_STAT));

  AST_CS_DURING_XFER: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !csNOut);                                                // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclkOut);                                              // R4
  AST_MOSI_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |-> $stable(mosiOut));                             // R4
  AST_SCLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclkOut) |-> $past(busy));                               // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (done && !statWr) |=> done);                                      // R7
endmodule

bind spi_user_xfer spi_user_xfer_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .sclkOut(sclkOut), .mosiOut(mosiOut),
  .csNOut(csNOut), .busy(ctrlBusy), .done(ctrlDone),
  .busAddr(busAddr), .busWrEn(busWrEn)
);

// File: tb/tb_spi_user_xfer.sv
module tb_spi_user_xfer;
  localparam int ADDR_W   = 7;
  localparam int HALF_CYC = 2;
  localparam logic [63:0] RESP_PAT = 64'h3C96_F00D_5AA5_1E2D;

  logic clk = 1'b0, rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic sclkOut, mosiOut, misoIn, csNOut;

  always #4 clk = ~clk;

  spi_user_xfer #(.ADDR_W(ADDR_W), .HALF_CYC(HALF_CYC)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .sclkOut(sclkOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .csNOut(csNOut)
  );

  int checks = 0, errors = 0;
  logic [511:0] capTx;
  int txCount = 0, rxCount = 0;
  realtime lastRise = 0, risePeriod = 0;

  // target model
  assign misoIn = RESP_PAT[rxCount % 64];
  always @(posedge sclkOut) begin
    capTx[txCount] = mosiOut;
    txCount++;
    risePeriod = $realtime - lastRise;
    lastRise = $realtime;
  end
  always @(negedge sclkOut) rxCount++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busAddr = ADDR_W'(a); busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    busAddr = ADDR_W'(a);
    #1 d = busRdata;
  endtask

  task automatic waitDone(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int k = 0; k < 6000; k++) begin
      rd('h30, s);
      if (s[4]) begin ok = 1; break; end
    end
  endtask

  function automatic int pos(input int i);
    return (i / 8) * 8 + 7 - (i % 8);
  endfunction

  task automatic clearSlave();
    txCount = 0; rxCount = 0; capTx = '0;
  endtask

  task automatic startXfer(input int nbits, input bit dout, input bit din,
                           input bit hold);
    wr('h1C, (32'(dout) << 27) | 32'(din));
    wr('h20, 32'(nbits - 1) << 17);
    wr('h2C, 32'(hold) << 30);
    wr('h30, 32'h0);
    clearSlave();
    wr('h00, 32'h1 << 18);
  endtask

  typedef struct packed {
    logic [9:0]  nbits;
    logic        dout, din, hold;
    logic [31:0] w0, w1;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{10'd8,  1'b1, 1'b1, 1'b0, 32'h0000_00A5, 32'h1111_1111},
    '{10'd16, 1'b1, 1'b0, 1'b0, 32'h7E5A_3C81, 32'h2222_2222},
    '{10'd13, 1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h3333_3333},
    '{10'd1,  1'b1, 1'b1, 1'b0, 32'h0000_0080, 32'h4444_4444},
    '{10'd64, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{10'd40, 1'b1, 1'b1, 1'b1, 32'h0123_4567, 32'h89AB_CDEF}
  };

  logic [511:0] model;
  logic [31:0]  rv;
  bit           ok;
  int           bad;

  initial begin
    fork
      begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(csNOut === 1'b1, "R1", "csN after reset", 32'(csNOut), 32'h1);
    chk(sclkOut === 1'b0, "R1", "sclk after reset", 32'(sclkOut), 32'h0);
    rd('h30, rv); chk(rv === 32'h0, "R1", "status after reset", rv, 32'h0);
    rd('h00, rv); chk(rv === 32'h0, "R1", "command after reset", rv, 32'h0);

    // table of transfers
    foreach (VECS[v]) begin
      wr('h40, VECS[v].w0);
      wr('h44, VECS[v].w1);
      model = '0;
      model[31:0] = VECS[v].w0;
      model[63:32] = VECS[v].w1;
      startXfer(int'(VECS[v].nbits), VECS[v].dout, VECS[v].din, VECS[v].hold);
      waitDone(ok);
      chk(ok, "R7", "done set at end", 32'(ok), 32'h1);
      chk(txCount == int'(VECS[v].nbits), "R3", "rising edge count",
          32'(txCount), 32'(VECS[v].nbits));
      bad = 0;
      for (int i = 0; i < int'(VECS[v].nbits); i++)
        if (capTx[i] !== (VECS[v].dout ? model[pos(i)] : 1'b0)) bad++;
      chk(bad == 0, VECS[v].dout ? "R4" : "R5", "MOSI bit stream mismatches",
          32'(bad), 32'h0);
      if (VECS[v].din)
        for (int i = 0; i < int'(VECS[v].nbits); i++)
          model[pos(i)] = RESP_PAT[i % 64];
      rd('h40, rv); chk(rv === model[31:0], "R6", "buffer word 0", rv, model[31:0]);
      rd('h44, rv); chk(rv === model[63:32], "R6", "buffer word 1", rv, model[63:32]);
      chk(csNOut === ~VECS[v].hold, "R8", "csN after transfer",
          32'(csNOut), 32'(~VECS[v].hold));
    end

    // R8 chip select still held before next start; released at next end
    repeat (10) @(negedge clk);
    chk(csNOut === 1'b0, "R8", "csN held between transfers", 32'(csNOut), 32'h0);
    startXfer(8, 1, 0, 0);
    waitDone(ok);
    chk(csNOut === 1'b1, "R8", "csN released after unheld end", 32'(csNOut), 32'h1);

    // R4 SCLK period
    chk(risePeriod == 2 * HALF_CYC * 8.0, "R4", "SCLK period ns",
        32'(int'(risePeriod)), 32'(2 * HALF_CYC * 8));

    // R7 done write semantics
    wr('h30, 32'h10);
    rd('h30, rv); chk(rv[4] === 1'b1, "R7", "done kept on write 1", 32'(rv[4]), 32'h1);
    wr('h30, 32'h0);
    rd('h30, rv); chk(rv[4] === 1'b0, "R7", "done cleared on write 0", 32'(rv[4]), 32'h0);

    // R2 busy readback, R9 start ignored while busy
    startXfer(64, 1, 1, 0);
    rd('h00, rv); chk(rv[18] === 1'b1, "R2", "busy bit during transfer", 32'(rv[18]), 32'h1);
    chk(csNOut === 1'b0, "R2", "csN low during transfer", 32'(csNOut), 32'h0);
    repeat (30) @(negedge clk);
    wr('h00, 32'h1 << 18);
    waitDone(ok);
    repeat (100) @(negedge clk);
    chk(txCount == 64, "R9", "edges after mid-transfer start", 32'(txCount), 32'd64);
    rd('h00, rv); chk(rv[18] === 1'b0, "R9", "idle after ignored start", 32'(rv[18]), 32'h0);

    // R10 soft reset mid transfer (done left set from before)
    wr('h1C, 32'h0800_0001);
    wr('h20, 32'd511 << 17);
    clearSlave();
    wr('h00, 32'h1 << 18);
    repeat (40) @(negedge clk);
    wr('h30, 32'h8000_0000);
    bad = txCount;
    repeat (30) @(negedge clk);
    chk(txCount == bad, "R10", "SCLK stopped after soft reset", 32'(txCount), 32'(bad));
    chk(csNOut === 1'b1, "R10", "csN after soft reset", 32'(csNOut), 32'h1);
    rd('h30, rv); chk(rv === 32'h0, "R10", "status after soft reset", rv, 32'h0);
    rd('h00, rv); chk(rv[18] === 1'b0, "R10", "busy after soft reset", 32'(rv[18]), 32'h0);
    wr('h30, 32'h4000_0000);
    rd('h30, rv); chk(rv[30] === 1'b0, "R10", "mode bit reads master", 32'(rv[30]), 32'h0);

    // full 512-bit transfer (R3, R4, R6)
    for (int w = 0; w < 16; w++) begin
      model[32*w +: 32] = 32'h9E37_79B9 * 32'(w + 1);
      wr('h40 + 4 * w, model[32*w +: 32]);
    end
    startXfer(512, 1, 1, 0);
    waitDone(ok);
    chk(txCount == 512, "R3", "full length edge count", 32'(txCount), 32'd512);
    bad = 0;
    for (int i = 0; i < 512; i++) if (capTx[i] !== model[pos(i)]) bad++;
    chk(bad == 0, "R4", "full length MOSI mismatches", 32'(bad), 32'h0);
    for (int i = 0; i < 512; i++) model[pos(i)] = RESP_PAT[i % 64];
    bad = 0;
    for (int w = 0; w < 16; w++) begin
      rd('h40 + 4 * w, rv);
      if (rv !== model[32*w +: 32]) bad++;
    end
    chk(bad == 0, "R6", "full buffer words mismatched", 32'(bad), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule